// File: doc/BRIEF.md
# Packed Instruction Fault Gate

This block sits in front of the execution unit for packed integer (SIMD) instructions. Each cycle it may be offered one decoded instruction: its escape byte, its opcode byte, an optional prefix byte, the emulation, task-switched and numeric-error control bits, a pending floating-point error flag, and memory-fault flags that address translation has already computed. From these it decides whether the instruction may go ahead or must trap. A trap is reported as an exception vector number.

The decision is registered. An allowed instruction yields a one-cycle issue pulse on the following cycle. A trapping instruction loads the vector into a holding register. That register keeps the vector stable until the trap handler side acknowledges it. While a vector is held, no new instruction is accepted. A separate active-low pin tells the outside world that a packed instruction ran into a pending floating-point error. It does this whether or not the numeric-error bit asks for an exception.

Top module: `pk_fault_gate`

## Requirements
- R1: During and right after reset, `issue_en` is 0, `flt_valid` is 0 and `fp_err_n` is 1.
- R2: A packed instruction has escape byte 0Fh and opcode 77h, 6Eh, 7Eh, 6Fh, 7Fh, 6Bh or 63h. A floating-point instruction has escape byte D8h to DFh. Any other instruction is issued without any fault check.
- R3: A packed instruction traps with vector 6 when `cr_em` is 1 or the prefix byte is F0h (with `pfx_present` 1). Vector 6 takes precedence over every other fault.
- R4: When `cr_ts` is 1, a packed or floating-point instruction traps with vector 7, unless vector 6 applies.
- R5: A packed instruction seen with `fp_pending` 1, and with neither vector 6 nor vector 7 applying, drives `fp_err_n` low from the next cycle. The pin stays low until an edge at which `fp_pending` is 0. It traps with vector 16 only if `cr_ne` is 1. With `cr_ne` 0 the remaining checks proceed as if no error were pending.
- R6: Below vector 16, memory faults on a packed instruction rank stack (12), then protection or limit (13), then page (14), then misalignment (17). Vector 17 applies only when `am_on` and `cpl_user` are both 1.
- R7: A prefix byte other than F0h (segment overrides 2Eh, 36h, 3Eh, 26h, 64h, 65h and address size 67h) causes no fault.
- R8: `issue_en` pulses for exactly the cycle after an accepted instruction that has no fault, and is never 1 while `flt_valid` is 1.
- R9: Once `flt_valid` is 1, `flt_vec` holds its value until a cycle with `flt_ack` 1. The next cycle `flt_valid` is 0. Requests offered while a vector is held produce neither an issue nor a new vector.
- R10: The empty-state opcode 0F 77h goes through the same vector 6, 7 and 16 checks as every other packed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An instruction is offered this cycle |
| op_lead | input | 8 | Escape / first opcode byte |
| op_code | input | 8 | Second opcode byte |
| pfx_present | input | 1 | A prefix byte accompanies the instruction |
| pfx_byte | input | 8 | Prefix byte value |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_ne | input | 1 | Numeric-error reporting control bit |
| fp_pending | input | 1 | A floating-point error is pending |
| mf_stack | input | 1 | Precomputed stack limit fault |
| mf_prot | input | 1 | Precomputed protection / real-mode limit fault |
| mf_page | input | 1 | Precomputed page fault |
| mf_misalign | input | 1 | Operand access is misaligned |
| am_on | input | 1 | Alignment mask enabled |
| cpl_user | input | 1 | Current privilege level is 3 |
| flt_ack | input | 1 | Held vector is acknowledged |
| issue_en | output | 1 | One-cycle permission to issue |
| flt_valid | output | 1 | A fault vector is held |
| flt_vec | output | VEC_W | Held exception vector number |
| fp_err_n | output | 1 | Active-low floating-point error pin |

## Verification
A wrong priority decision shows up as a wrong `flt_vec` on the cycle after the offending request. It is therefore visible one clock after the stimulus. A holding register that drops or changes its vector before acknowledgement shows as a changed `flt_vec` or a lost `flt_valid` within the held window. It also shows as a spurious `issue_en` for a request that should have been blocked. A broken error-pin state is exposed on the cycle after a pending error meets a packed instruction, and again on the cycle after the pending flag falls.

// File: rtl/pk_fault_gate.sv
module pk_fault_gate #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       op_lead,
  input  logic [7:0]       op_code,
  input  logic             pfx_present,
  input  logic [7:0]       pfx_byte,
  input  logic             cr_em,
  input  logic             cr_ts,
  input  logic             cr_ne,
  input  logic             fp_pending,
  input  logic             mf_stack,
  input  logic             mf_prot,
  input  logic             mf_page,
  input  logic             mf_misalign,
  input  logic             am_on,
  input  logic             cpl_user,
  input  logic             flt_ack,
  output logic             issue_en,
  output logic             flt_valid,
  output logic [VEC_W-1:0] flt_vec,
  output logic             fp_err_n
);

  localparam logic [VEC_W-1:0] V_UD    = VEC_W'(6);
  localparam logic [VEC_W-1:0] V_NM    = VEC_W'(7);
  localparam logic [VEC_W-1:0] V_SS    = VEC_W'(12);
  localparam logic [VEC_W-1:0] V_GP    = VEC_W'(13);
  localparam logic [VEC_W-1:0] V_PF    = VEC_W'(14);
  localparam logic [VEC_W-1:0] V_MF    = VEC_W'(16);
  localparam logic [VEC_W-1:0] V_AC    = VEC_W'(17);

  logic is_pk, is_fp, lock_hit;
  logic f_ud, f_nm, err_hit, f_mf, f_ac;
  logic any_fault, accept;
  logic [VEC_W-1:0] pick;

  assign is_pk    = (op_lead == 8'h0F) &&
                    (op_code inside {8'h77, 8'h6E, 8'h7E, 8'h6F, 8'h7F, 8'h6B, 8'h63});
  assign is_fp    = (op_lead[7:3] == 5'b11011);
  assign lock_hit = pfx_present && (pfx_byte == 8'hF0);

  assign f_ud    = is_pk && (cr_em || lock_hit);
  assign f_nm    = (is_pk || is_fp) && cr_ts;
  assign err_hit = is_pk && fp_pending;
  assign f_mf    = err_hit && cr_ne;
  assign f_ac    = mf_misalign && am_on && cpl_user;

  always_comb begin
    pick = '0;
    if (f_ud)                pick = V_UD;
    else if (f_nm)           pick = V_NM;
    else if (f_mf)           pick = V_MF;
    else if (is_pk) begin
      if (mf_stack)          pick = V_SS;
      else if (mf_prot)      pick = V_GP;
      else if (mf_page)      pick = V_PF;
      else if (f_ac)         pick = V_AC;
    end
  end

  assign any_fault = (pick != '0);
  assign accept    = req_valid && !flt_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_en  <= 1'b0;
      flt_valid <= 1'b0;
      flt_vec   <= '0;
    end else if (flt_valid) begin
      issue_en <= 1'b0;
      if (flt_ack) flt_valid <= 1'b0;
    end else begin
      issue_en <= accept && !any_fault;
      if (accept && any_fault) begin
        flt_valid <= 1'b1;
        flt_vec   <= pick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                fp_err_n <= 1'b1;
    else if (accept && err_hit && !f_ud && !f_nm) fp_err_n <= 1'b0;
    else if (!fp_pending)                      fp_err_n <= 1'b1;
  end

endmodule

// File: rtl/pk_fault_gate_chk.sv
module pk_fault_gate_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [7:0]       op_lead,
  input logic [7:0]       op_code,
  input logic             cr_em,
  input logic             flt_ack,
  input logic             issue_en,
  input logic             flt_valid,
  input logic [VEC_W-1:0] flt_vec
);

  assert_issue_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_en && flt_valid));

  assert_issue_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && flt_valid |=> !issue_en);

  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_ack |=> flt_valid && $stable(flt_vec));

  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && flt_ack |=> !flt_valid);

  assert_vec_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (flt_vec inside {VEC_W'(6), VEC_W'(7), VEC_W'(12), VEC_W'(13),
                                   VEC_W'(14), VEC_W'(16), VEC_W'(17)}));

  assert_empty_em_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !flt_valid && cr_em && op_lead == 8'h0F && op_code == 8'h77
    |=> flt_valid && flt_vec == VEC_W'(6));

endmodule

bind pk_fault_gate pk_fault_gate_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_lead(op_lead),
  .op_code(op_code), .cr_em(cr_em), .flt_ack(flt_ack), .issue_en(issue_en),
  .flt_valid(flt_valid), .flt_vec(flt_vec));

// File: tb/pk_fault_gate_test.sv
module pk_fault_gate_test;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, pfx_present = 0, cr_em = 0, cr_ts = 0, cr_ne = 0, fp_pending = 0;
  logic mf_stack = 0, mf_prot = 0, mf_page = 0, mf_misalign = 0, am_on = 0, cpl_user = 0, flt_ack = 0;
  logic [7:0] op_lead = 8'h90, op_code = 8'h00, pfx_byte = 8'h00;
  logic issue_en, flt_valid, fp_err_n;
  logic [VW-1:0] flt_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  logic e_issue = 0, e_valid = 0, e_err = 1;
  logic [VW-1:0] e_vec = '0;
  string e_tag = "R1";

  always #4 clk = ~clk;

  pk_fault_gate #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_lead(op_lead), .op_code(op_code),
    .pfx_present(pfx_present), .pfx_byte(pfx_byte), .cr_em(cr_em), .cr_ts(cr_ts),
    .cr_ne(cr_ne), .fp_pending(fp_pending), .mf_stack(mf_stack), .mf_prot(mf_prot),
    .mf_page(mf_page), .mf_misalign(mf_misalign), .am_on(am_on), .cpl_user(cpl_user),
    .flt_ack(flt_ack), .issue_en(issue_en), .flt_valid(flt_valid), .flt_vec(flt_vec),
    .fp_err_n(fp_err_n));

  function automatic bit pk_op(input logic [7:0] a, input logic [7:0] b);
    return a == 8'h0F && (b == 8'h77 || b == 8'h6E || b == 8'h7E || b == 8'h6F ||
                          b == 8'h7F || b == 8'h6B || b == 8'h63);
  endfunction

  function automatic int want_vec();
    bit pk = pk_op(op_lead, op_code);
    bit fp = op_lead >= 8'hD8 && op_lead <= 8'hDF;
    if (pk && (cr_em || (pfx_present && pfx_byte == 8'hF0))) return 6;
    if ((pk || fp) && cr_ts) return 7;
    if (!pk) return 0;
    if (fp_pending && cr_ne) return 16;
    if (mf_stack) return 12;
    if (mf_prot) return 13;
    if (mf_page) return 14;
    if (mf_misalign && am_on && cpl_user) return 17;
    return 0;
  endfunction

  function automatic string tag_of(input int v);
    case (v)
      6: return "R3";  7: return "R4";  16: return "R5";
      0: return "R8";  default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    logic n_issue, n_valid, n_err;
    logic [VW-1:0] n_vec;
    int v;
    bit acc, pk;
    n_issue = 0; n_valid = e_valid; n_vec = e_vec; n_err = e_err;
    acc = req_valid && !e_valid;
    pk = pk_op(op_lead, op_code);
    v = want_vec();
    if (!rst_n) begin
      n_valid = 0; n_vec = '0; n_err = 1; e_tag = "R1";
    end else begin
      if (e_valid) begin
        if (flt_ack) n_valid = 0;
        e_tag = "R9";
      end else if (acc) begin
        e_tag = tag_of(v);
        if (v == 0) n_issue = 1;
        else begin n_valid = 1; n_vec = VW'(v); end
      end else e_tag = "R8";
      if (acc && pk && fp_pending && v != 6 && v != 7) n_err = 0;
      else if (!fp_pending) n_err = 1;
    end
    @(posedge clk);
    e_issue = n_issue; e_valid = n_valid; e_vec = n_vec; e_err = n_err;
    @(negedge clk);
    check(e_tag, "issue_en", int'(issue_en), int'(e_issue));
    check(e_tag, "flt_valid", int'(flt_valid), int'(e_valid));
    if (e_valid) check(e_tag, "flt_vec", int'(flt_vec), int'(e_vec));
    check(fp_pending ? "R5" : e_tag, "fp_err_n", int'(fp_err_n), int'(e_err));
  endtask

  task automatic clear_in();
    req_valid = 0; pfx_present = 0; pfx_byte = 0; cr_em = 0; cr_ts = 0; cr_ne = 0;
    fp_pending = 0; mf_stack = 0; mf_prot = 0; mf_page = 0; mf_misalign = 0;
    am_on = 0; cpl_user = 0; flt_ack = 0; op_lead = 8'h90; op_code = 8'h00;
  endtask

  task automatic offer(input logic [7:0] a, input logic [7:0] b);
    req_valid = 1; op_lead = a; op_code = b;
    tick();
    req_valid = 0;
    if (e_valid) begin flt_ack = 1; tick(); flt_ack = 0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pk_list [7] = '{8'h77, 8'h6E, 8'h7E, 8'h6F, 8'h7F, 8'h6B, 8'h63};
    logic [7:0] seg_list [7] = '{8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h67};
    void'($urandom(32'd4242));
    @(negedge clk);
    tick(); tick();                      // R1 while in reset
    rst_n = 1;
    tick();                              // R1 right after reset

    // R10: empty-state under EM, TS, pending error
    cr_em = 1; offer(8'h0F, 8'h77); clear_in();
    cr_ts = 1; offer(8'h0F, 8'h77); clear_in();
    fp_pending = 1; cr_ne = 1; offer(8'h0F, 8'h77); fp_pending = 0; tick(); clear_in();
    // R3: lock prefix outranks TS and pending error
    pfx_present = 1; pfx_byte = 8'hF0; cr_ts = 1; fp_pending = 1; cr_ne = 1;
    offer(8'h0F, 8'h6F); fp_pending = 0; tick(); clear_in();
    // R4: TS on a floating-point opcode; R2: FP without TS issues
    cr_ts = 1; offer(8'hD9, 8'hC0); clear_in();
    offer(8'hDD, 8'h00);
    // R2: unrelated opcode ignores EM
    cr_em = 1; offer(8'h0F, 8'hA2); clear_in();
    // R5: NE clear -> pin low, instruction still issues, pin held then released
    fp_pending = 1; offer(8'h0F, 8'h7E); tick(); tick(); fp_pending = 0; tick(); tick(); clear_in();
    // R6: priority chain and alignment qualification
    mf_stack = 1; mf_prot = 1; mf_page = 1; offer(8'h0F, 8'h6E); clear_in();
    mf_prot = 1; mf_page = 1; offer(8'h0F, 8'h6E); clear_in();
    mf_misalign = 1; am_on = 1; offer(8'h0F, 8'h7F);
    cpl_user = 1; offer(8'h0F, 8'h7F); clear_in();
    // R7: segment / address-size prefixes legal
    foreach (seg_list[i]) begin
      pfx_present = 1; pfx_byte = seg_list[i]; offer(8'h0F, pk_list[i]);
    end
    clear_in();
    // R9: requests while held are dropped
    cr_em = 1; req_valid = 1; op_lead = 8'h0F; op_code = 8'h63; tick();
    cr_em = 0; cr_ts = 0; op_code = 8'h6B; tick(); tick();
    req_valid = 0; flt_ack = 1; tick(); flt_ack = 0; tick(); clear_in();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int s = $urandom_range(0, 9);
      req_valid   = ($urandom_range(0, 7) != 0);
      op_lead     = (s < 6) ? 8'h0F : (s < 8) ? 8'hD8 + 8'($urandom_range(0, 7)) : 8'($urandom);
      op_code     = (s < 6) ? pk_list[$urandom_range(0, 6)] : 8'($urandom);
      pfx_present = ($urandom_range(0, 3) == 0);
      pfx_byte    = ($urandom_range(0, 2) == 0) ? 8'hF0 : seg_list[$urandom_range(0, 6)];
      cr_em       = ($urandom_range(0, 7) == 0);
      cr_ts       = ($urandom_range(0, 5) == 0);
      cr_ne       = $urandom_range(0, 1) == 1;
      fp_pending  = ($urandom_range(0, 4) == 0);
      mf_stack    = ($urandom_range(0, 9) == 0);
      mf_prot     = ($urandom_range(0, 9) == 0);
      mf_page     = ($urandom_range(0, 9) == 0);
      mf_misalign = ($urandom_range(0, 3) == 0);
      am_on       = $urandom_range(0, 1) == 1;
      cpl_user    = $urandom_range(0, 1) == 1;
      flt_ack     = ($urandom_range(0, 2) == 0);
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule